// File: doc/BRIEF.md
# Cache-Side Coherence Line Controller with Reorder Detection

This block is the cache end of a four-state (Modified, Owned, Shared, Invalid) directory coherence scheme. It keeps a small array of per-line states and data tokens. It takes load, store and evict requests from the processor and sends request messages to the directory. It accepts forwarded messages and responses from the network and answers them.

The controller assumes that messages between two endpoints arrive in the order they were sent. One reordering matters: a writeback acknowledgement can overtake an exclusive forward. The controller has no transient states to absorb that race. An exclusive forward that finds the line without a valid copy is treated as a failed speculation. The block raises a one-cycle recovery pulse and then holds a sticky error flag, which stays set until an external recover strobe returns every line to Invalid.

The block keeps one transaction outstanding at a time. The output message port is shared. Incoming messages take precedence over a pending reissue, and a pending reissue takes precedence over new processor work.

Top module: `dircache_ctrl`

## Requirements
- R1: After reset every line reads Invalid (state code 0; S=1, O=2, M=3, writeback-pending=4), no message or completion is issued, and `procReady` is 1.
- R2: A load to a line without a copy sends a read request (type 0) on the request network (vnet 0) one cycle later. `procReady` stays low until a Data response (type 8, vnet 2) for that line arrives. The line then becomes Shared, takes the response token, and `procDone` pulses with that token.
- R3: A store to a line that is not Modified sends a write request (type 1, vnet 0). A Data or Ack (type 9) response for that line makes it Modified, holding the store's token, and `procDone` returns that token.
- R4: Load hits (S, O, M) and store hits (M) complete with `procDone` one cycle later and send no message. A store hit replaces the line token.
- R5: Evicting an M or O line sends a Writeback (type 2, vnet 0) carrying the line token and moves the line to writeback-pending. A pending line still answers read forwards with Data. Evicting a Shared line silently makes it Invalid and completes.
- R6: A writeback acknowledgement (type 7, vnet 1) makes the line Invalid and completes a pending writeback with `procDone`.
- R7: A read forward (type 4, vnet 1) to an M line replies Data (type 8, vnet 2) with the token and downgrades the line to Owned. Repeated read forwards to an Owner each reply and never raise an error.
- R8: An exclusive forward (type 5, vnet 1) to an M, O or pending line replies Data and invalidates the line. To a Shared line it invalidates with no reply.
- R9: An exclusive forward to an Invalid line pulses `misSpec` for exactly one cycle, leaves every line state unchanged, sets `errSticky`, and drops `procReady`.
- R10: While `errSticky` is set, messages and processor requests are ignored. A `recover` strobe clears every line to Invalid and clears `errSticky` by the next cycle.
- R11: A Nack (type 10, vnet 2) to a pending writeback returns the line to its previous stable state. The same request is reissued one cycle later. A Nack to a read or write request reissues that request.
- R12: An invalidation (type 6, vnet 1) makes a Shared line Invalid and replies Ack (type 9, vnet 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| recover | input | 1 | Clears all lines to Invalid and clears the error flag |
| procValid | input | 1 | Processor request strobe |
| procOp | input | 2 | 0 load, 1 store, 2 evict |
| procLine | input | LINE_W | Line index of the request; also selects `procState` |
| procWrToken | input | TOK_W | Token written by a store |
| procReady | output | 1 | A processor request is taken this cycle |
| procState | output | 3 | Current state of line `procLine` |
| procDone | output | 1 | Processor request completed |
| procToken | output | TOK_W | Token returned on completion |
| msgValid | input | 1 | Incoming message strobe |
| msgVnet | input | 2 | Incoming virtual network id |
| msgType | input | 4 | Incoming message type |
| msgLine | input | LINE_W | Incoming line index |
| msgToken | input | TOK_W | Incoming data token |
| outValid | output | 1 | Outgoing message strobe |
| outVnet | output | 2 | Outgoing virtual network id |
| outType | output | 4 | Outgoing message type |
| outLine | output | LINE_W | Outgoing line index |
| outToken | output | TOK_W | Outgoing data token |
| misSpec | output | 1 | One-cycle recovery request |
| errSticky | output | 1 | Held after a recovery request until `recover` |

## Verification
Outgoing messages, `procDone`, `misSpec` and line-state updates are registered. Each appears one clock edge after the edge that captures its stimulus. A reissue after a Nack appears one edge later still. The bench drives inputs just after a falling edge, so they are captured at the next rising edge, and it compares results at the falling edge that follows. Expected messages, completions and pulses sit in queues that are filled before the stimulus is applied. A monitor pops one entry per observed output at each falling edge, so an output that arrives late, early or when none is expected shows up as a mismatch.

// File: rtl/dircache_pkg.sv
package dircache_pkg;

  typedef enum logic [2:0] {
    LS_I  = 3'd0,
    LS_S  = 3'd1,
    LS_O  = 3'd2,
    LS_M  = 3'd3,
    LS_WB = 3'd4
  } lineStateT;

  typedef enum logic [1:0] {
    VN_REQ   = 2'd0,
    VN_FWD   = 2'd1,
    VN_RESP  = 2'd2,
    VN_FINAL = 2'd3
  } vnetT;

  typedef enum logic [3:0] {
    MT_GET_RD  = 4'd0,
    MT_GET_WR  = 4'd1,
    MT_PUT     = 4'd2,
    MT_FWD_RD  = 4'd4,
    MT_FWD_WR  = 4'd5,
    MT_INVAL   = 4'd6,
    MT_PUT_ACK = 4'd7,
    MT_DATA    = 4'd8,
    MT_ACK     = 4'd9,
    MT_NACK    = 4'd10
  } msgTypeT;

  localparam logic [1:0] OP_LOAD  = 2'd0;
  localparam logic [1:0] OP_STORE = 2'd1;
  localparam logic [1:0] OP_EVICT = 2'd2;

  typedef struct packed {
    logic      wrState;
    lineStateT newState;
    logic      wrTok;
    logic      send;
    vnetT      sendVnet;
    msgTypeT   sendType;
    logic      done;
    logic      misSpec;
    logic      clearAll;
  } strobeT;

  function automatic logic ownsLine(lineStateT st);
    return (st == LS_M) || (st == LS_O) || (st == LS_WB);
  endfunction

  function automatic logic canRead(lineStateT st);
    return (st == LS_S) || (st == LS_O) || (st == LS_M);
  endfunction

endpackage

// File: rtl/dircache_lines.sv
module dircache_lines
  import dircache_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int TOK_W     = 8,
  parameter int LINE_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [LINE_W-1:0] wrLine,
  input  logic [TOK_W-1:0]  wrTokVal,
  input  logic [LINE_W-1:0] sendLine,
  input  logic [TOK_W-1:0]  sendTok,
  input  logic [TOK_W-1:0]  doneTok,
  input  logic [LINE_W-1:0] rdLineA,
  input  logic [LINE_W-1:0] rdLineB,
  input  logic [LINE_W-1:0] rdLineC,
  output lineStateT         rdStA,
  output lineStateT         rdStB,
  output lineStateT         rdStC,
  output logic [TOK_W-1:0]  rdTokA,
  output logic [TOK_W-1:0]  rdTokB,
  output logic [TOK_W-1:0]  rdTokC,
  output logic              outValid,
  output logic [1:0]        outVnet,
  output logic [3:0]        outType,
  output logic [LINE_W-1:0] outLine,
  output logic [TOK_W-1:0]  outToken,
  output logic              procDone,
  output logic [TOK_W-1:0]  procToken,
  output logic              misSpec
);

  logic [NUM_LINES-1:0][2:0]       stAll;
  logic [NUM_LINES-1:0][TOK_W-1:0] tokAll;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    lineStateT        stQ;
    logic [TOK_W-1:0] tokQ;
    logic             hit;

    assign hit = (wrLine == LINE_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stQ  <= LS_I;
        tokQ <= '0;
      end else if (strb.clearAll) begin
        stQ  <= LS_I;
        tokQ <= '0;
      end else begin
        if (strb.wrState && hit) stQ  <= strb.newState;
        if (strb.wrTok && hit)   tokQ <= wrTokVal;
      end
    end

    assign stAll[g]  = stQ;
    assign tokAll[g] = tokQ;
  end

  assign rdStA  = lineStateT'(stAll[rdLineA]);
  assign rdStB  = lineStateT'(stAll[rdLineB]);
  assign rdStC  = lineStateT'(stAll[rdLineC]);
  assign rdTokA = tokAll[rdLineA];
  assign rdTokB = tokAll[rdLineB];
  assign rdTokC = tokAll[rdLineC];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outVnet   <= '0;
      outType   <= '0;
      outLine   <= '0;
      outToken  <= '0;
      procDone  <= 1'b0;
      procToken <= '0;
      misSpec   <= 1'b0;
    end else if (strb.clearAll) begin
      outValid  <= 1'b0;
      outVnet   <= '0;
      outType   <= '0;
      outLine   <= '0;
      outToken  <= '0;
      procDone  <= 1'b0;
      procToken <= '0;
      misSpec   <= 1'b0;
    end else begin
      outValid  <= strb.send;
      outVnet   <= strb.send ? strb.sendVnet : 2'd0;
      outType   <= strb.send ? strb.sendType : 4'd0;
      outLine   <= strb.send ? sendLine : '0;
      outToken  <= strb.send ? sendTok : '0;
      procDone  <= strb.done;
      procToken <= strb.done ? doneTok : '0;
      misSpec   <= strb.misSpec;
    end
  end

endmodule

// File: rtl/dircache_fsm.sv
module dircache_fsm
  import dircache_pkg::*;
#(
  parameter int TOK_W  = 8,
  parameter int LINE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              recover,
  input  logic              procValid,
  input  logic [1:0]        procOp,
  input  logic [LINE_W-1:0] procLine,
  input  logic [TOK_W-1:0]  procWrToken,
  input  logic              msgValid,
  input  logic [1:0]        msgVnet,
  input  logic [3:0]        msgType,
  input  logic [LINE_W-1:0] msgLine,
  input  logic [TOK_W-1:0]  msgToken,
  input  lineStateT         procSt,
  input  logic [TOK_W-1:0]  procTok,
  input  lineStateT         msgSt,
  input  logic [TOK_W-1:0]  msgTok,
  input  logic [TOK_W-1:0]  pendTokC,
  output logic [LINE_W-1:0] pendLine,
  output strobeT            strb,
  output logic [LINE_W-1:0] wrLine,
  output logic [TOK_W-1:0]  wrTokVal,
  output logic [LINE_W-1:0] sendLine,
  output logic [TOK_W-1:0]  sendTok,
  output logic [TOK_W-1:0]  doneTok,
  output logic              procReady,
  output logic              errSticky
);

  logic              busyQ, busyD;
  logic [LINE_W-1:0] pendLineQ, pendLineD;
  msgTypeT           pendKindQ, pendKindD;
  logic [TOK_W-1:0]  pendTokQ, pendTokD;
  lineStateT         prevStQ, prevStD;
  logic              reissueQ, reissueD;
  logic              errQ, errD;

  assign pendLine  = pendLineQ;
  assign errSticky = errQ;
  assign procReady = !busyQ && !errQ && !msgValid && !reissueQ && !recover;

  always_comb begin
    strb      = '0;
    wrLine    = '0;
    wrTokVal  = '0;
    sendLine  = '0;
    sendTok   = '0;
    doneTok   = '0;
    busyD     = busyQ;
    pendLineD = pendLineQ;
    pendKindD = pendKindQ;
    pendTokD  = pendTokQ;
    prevStD   = prevStQ;
    reissueD  = reissueQ;
    errD      = errQ;

    if (recover) begin
      strb.clearAll = 1'b1;
      busyD         = 1'b0;
      reissueD      = 1'b0;
      errD          = 1'b0;
    end else if (errQ) begin
      // frozen until recover
    end else if (msgValid) begin
      wrLine   = msgLine;
      sendLine = msgLine;
      if (msgVnet == VN_FWD) begin
        case (msgType)
          MT_FWD_RD: begin
            if (ownsLine(msgSt)) begin
              strb.send     = 1'b1;
              strb.sendVnet = VN_RESP;
              strb.sendType = MT_DATA;
              sendTok       = msgTok;
              if (msgSt == LS_M) begin
                strb.wrState  = 1'b1;
                strb.newState = LS_O;
              end
            end
          end
          MT_FWD_WR: begin
            if (msgSt == LS_I) begin
              strb.misSpec = 1'b1;
              errD         = 1'b1;
            end else begin
              strb.wrState  = 1'b1;
              strb.newState = LS_I;
              if (ownsLine(msgSt)) begin
                strb.send     = 1'b1;
                strb.sendVnet = VN_RESP;
                strb.sendType = MT_DATA;
                sendTok       = msgTok;
              end
            end
          end
          MT_INVAL: begin
            if (msgSt == LS_S) begin
              strb.wrState  = 1'b1;
              strb.newState = LS_I;
            end
            strb.send     = 1'b1;
            strb.sendVnet = VN_RESP;
            strb.sendType = MT_ACK;
          end
          MT_PUT_ACK: begin
            strb.wrState  = 1'b1;
            strb.newState = LS_I;
            if (busyQ && pendKindQ == MT_PUT && pendLineQ == msgLine) begin
              busyD     = 1'b0;
              strb.done = 1'b1;
            end
          end
          default: ;
        endcase
      end else if (msgVnet == VN_RESP && busyQ && msgLine == pendLineQ) begin
        case (msgType)
          MT_DATA, MT_ACK: begin
            if (pendKindQ == MT_GET_RD && msgType == MT_DATA) begin
              strb.wrState  = 1'b1;
              strb.newState = LS_S;
              strb.wrTok    = 1'b1;
              wrTokVal      = msgToken;
              strb.done     = 1'b1;
              doneTok       = msgToken;
              busyD         = 1'b0;
            end else if (pendKindQ == MT_GET_WR) begin
              strb.wrState  = 1'b1;
              strb.newState = LS_M;
              strb.wrTok    = 1'b1;
              wrTokVal      = pendTokQ;
              strb.done     = 1'b1;
              doneTok       = pendTokQ;
              busyD         = 1'b0;
            end
          end
          MT_NACK: begin
            if (pendKindQ == MT_PUT) begin
              if (msgSt == LS_WB) begin
                strb.wrState  = 1'b1;
                strb.newState = prevStQ;
                reissueD      = 1'b1;
              end else begin
                busyD     = 1'b0;
                strb.done = 1'b1;
              end
            end else begin
              reissueD = 1'b1;
            end
          end
          default: ;
        endcase
      end
    end else if (reissueQ) begin
      reissueD      = 1'b0;
      strb.send     = 1'b1;
      strb.sendVnet = VN_REQ;
      strb.sendType = pendKindQ;
      sendLine      = pendLineQ;
      if (pendKindQ == MT_PUT) begin
        sendTok       = pendTokC;
        wrLine        = pendLineQ;
        strb.wrState  = 1'b1;
        strb.newState = LS_WB;
      end
    end else if (procValid && !busyQ) begin
      wrLine   = procLine;
      sendLine = procLine;
      case (procOp)
        OP_LOAD: begin
          if (canRead(procSt)) begin
            strb.done = 1'b1;
            doneTok   = procTok;
          end else begin
            strb.send     = 1'b1;
            strb.sendVnet = VN_REQ;
            strb.sendType = MT_GET_RD;
            busyD         = 1'b1;
            pendLineD     = procLine;
            pendKindD     = MT_GET_RD;
          end
        end
        OP_STORE: begin
          if (procSt == LS_M) begin
            strb.wrTok = 1'b1;
            wrTokVal   = procWrToken;
            strb.done  = 1'b1;
            doneTok    = procWrToken;
          end else begin
            strb.send     = 1'b1;
            strb.sendVnet = VN_REQ;
            strb.sendType = MT_GET_WR;
            busyD         = 1'b1;
            pendLineD     = procLine;
            pendKindD     = MT_GET_WR;
            pendTokD      = procWrToken;
          end
        end
        OP_EVICT: begin
          if (procSt == LS_M || procSt == LS_O) begin
            strb.send     = 1'b1;
            strb.sendVnet = VN_REQ;
            strb.sendType = MT_PUT;
            sendTok       = procTok;
            strb.wrState  = 1'b1;
            strb.newState = LS_WB;
            busyD         = 1'b1;
            pendLineD     = procLine;
            pendKindD     = MT_PUT;
            prevStD       = procSt;
          end else begin
            if (procSt == LS_S) begin
              strb.wrState  = 1'b1;
              strb.newState = LS_I;
            end
            strb.done = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ     <= 1'b0;
      pendLineQ <= '0;
      pendKindQ <= MT_GET_RD;
      pendTokQ  <= '0;
      prevStQ   <= LS_I;
      reissueQ  <= 1'b0;
      errQ      <= 1'b0;
    end else begin
      busyQ     <= busyD;
      pendLineQ <= pendLineD;
      pendKindQ <= pendKindD;
      pendTokQ  <= pendTokD;
      prevStQ   <= prevStD;
      reissueQ  <= reissueD;
      errQ      <= errD;
    end
  end

endmodule

// File: rtl/dircache_ctrl.sv
module dircache_ctrl
  import dircache_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int TOK_W     = 8,
  localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              recover,
  input  logic              procValid,
  input  logic [1:0]        procOp,
  input  logic [LINE_W-1:0] procLine,
  input  logic [TOK_W-1:0]  procWrToken,
  output logic              procReady,
  output logic [2:0]        procState,
  output logic              procDone,
  output logic [TOK_W-1:0]  procToken,
  input  logic              msgValid,
  input  logic [1:0]        msgVnet,
  input  logic [3:0]        msgType,
  input  logic [LINE_W-1:0] msgLine,
  input  logic [TOK_W-1:0]  msgToken,
  output logic              outValid,
  output logic [1:0]        outVnet,
  output logic [3:0]        outType,
  output logic [LINE_W-1:0] outLine,
  output logic [TOK_W-1:0]  outToken,
  output logic              misSpec,
  output logic              errSticky
);

  strobeT            strb;
  logic [LINE_W-1:0] wrLine, sendLine, pendLine;
  logic [TOK_W-1:0]  wrTokVal, sendTok, doneTok;
  lineStateT         stA, stB, stC;
  logic [TOK_W-1:0]  tokA, tokB, tokC;

  dircache_fsm #(.TOK_W(TOK_W), .LINE_W(LINE_W)) u_fsm (
    .clk         (clk),
    .rstN        (rstN),
    .recover     (recover),
    .procValid   (procValid),
    .procOp      (procOp),
    .procLine    (procLine),
    .procWrToken (procWrToken),
    .msgValid    (msgValid),
    .msgVnet     (msgVnet),
    .msgType     (msgType),
    .msgLine     (msgLine),
    .msgToken    (msgToken),
    .procSt      (stA),
    .procTok     (tokA),
    .msgSt       (stB),
    .msgTok      (tokB),
    .pendTokC    (tokC),
    .pendLine    (pendLine),
    .strb        (strb),
    .wrLine      (wrLine),
    .wrTokVal    (wrTokVal),
    .sendLine    (sendLine),
    .sendTok     (sendTok),
    .doneTok     (doneTok),
    .procReady   (procReady),
    .errSticky   (errSticky)
  );

  dircache_lines #(.NUM_LINES(NUM_LINES), .TOK_W(TOK_W), .LINE_W(LINE_W)) u_lines (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrLine    (wrLine),
    .wrTokVal  (wrTokVal),
    .sendLine  (sendLine),
    .sendTok   (sendTok),
    .doneTok   (doneTok),
    .rdLineA   (procLine),
    .rdLineB   (msgLine),
    .rdLineC   (pendLine),
    .rdStA     (stA),
    .rdStB     (stB),
    .rdStC     (stC),
    .rdTokA    (tokA),
    .rdTokB    (tokB),
    .rdTokC    (tokC),
    .outValid  (outValid),
    .outVnet   (outVnet),
    .outType   (outType),
    .outLine   (outLine),
    .outToken  (outToken),
    .procDone  (procDone),
    .procToken (procToken),
    .misSpec   (misSpec)
  );

  logic [2:0] unusedSt;
  assign unusedSt  = stC;
  assign procState = stA;

endmodule

// File: rtl/dircache_ctrl_chk.sv
module dircache_ctrl_chk #(
  parameter int TOK_W  = 8,
  parameter int LINE_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              recover,
  input logic              procValid,
  input logic [1:0]        procOp,
  input logic              procReady,
  input logic [2:0]        procState,
  input logic              procDone,
  input logic              outValid,
  input logic [1:0]        outVnet,
  input logic [3:0]        outType,
  input logic              misSpec,
  input logic              errSticky
);

  // R9: recovery request lasts one cycle
  p_pulse_once_r9: assert property (@(posedge clk) disable iff (!rstN)
    misSpec |=> !misSpec);

  // R9: the error flag is up whenever the pulse is
  p_sticky_with_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    misSpec |-> errSticky);

  // R10: nothing leaves the block while the error flag holds
  p_quiet_in_error_r10: assert property (@(posedge clk) disable iff (!rstN)
    errSticky |-> (!outValid && !procDone));

  // R10: recover leaves an invalid array and a clear flag
  p_recover_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    recover |=> (!errSticky && procState == 3'd0));

  // R1: no request is accepted during an error
  p_ready_not_err_r1: assert property (@(posedge clk) disable iff (!rstN)
    procReady |-> !errSticky);

  // R2: processor requests travel on the request network
  p_req_vnet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outType <= 4'd2) |-> outVnet == 2'd0);

  // R7: data and ack replies travel on the response network
  p_reply_vnet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && (outType == 4'd8 || outType == 4'd9)) |-> outVnet == 2'd2);

  // R4: a load hit completes next cycle with no message
  p_load_hit_r4: assert property (@(posedge clk) disable iff (!rstN)
    (procValid && procReady && procOp == 2'd0 &&
     (procState == 3'd1 || procState == 3'd2 || procState == 3'd3))
    |=> (procDone && !outValid));

endmodule

bind dircache_ctrl dircache_ctrl_chk #(.TOK_W(TOK_W), .LINE_W(LINE_W)) u_chk (.*);

// File: tb/dircache_ctrl_test.sv
`timescale 1ns/1ps
module dircache_ctrl_test;

  localparam int NL = 8;
  localparam int TW = 8;
  localparam int LW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          recover = 1'b0;
  logic          procValid = 1'b0;
  logic [1:0]    procOp = '0;
  logic [LW-1:0] procLine = '0;
  logic [TW-1:0] procWrToken = '0;
  logic          procReady;
  logic [2:0]    procState;
  logic          procDone;
  logic [TW-1:0] procToken;
  logic          msgValid = 1'b0;
  logic [1:0]    msgVnet = '0;
  logic [3:0]    msgType = '0;
  logic [LW-1:0] msgLine = '0;
  logic [TW-1:0] msgToken = '0;
  logic          outValid;
  logic [1:0]    outVnet;
  logic [3:0]    outType;
  logic [LW-1:0] outLine;
  logic [TW-1:0] outToken;
  logic          misSpec;
  logic          errSticky;

  always #2.5 clk = ~clk;

  dircache_ctrl #(.NUM_LINES(NL), .TOK_W(TW)) uut (.*);

  typedef struct {
    logic [1:0]    vnet;
    logic [3:0]    typ;
    logic [LW-1:0] line;
    logic [TW-1:0] tok;
    string         tag;
  } expMsgT;

  typedef struct {
    logic [TW-1:0] tok;
    string         tag;
  } expDoneT;

  expMsgT  msgQ[$];
  expDoneT doneQ[$];
  string   missQ[$];
  int      tests = 0;
  int      fails = 0;
  bit      finished = 1'b0;

  task automatic check(string tag, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: outputs are compared on every falling edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (outValid) begin
        if (msgQ.size() == 0) check("R4", "unexpected message type", int'(outType), 99);
        else begin
          expMsgT e;
          e = msgQ.pop_front();
          check(e.tag, "msg vnet", int'(outVnet), int'(e.vnet));
          check(e.tag, "msg type", int'(outType), int'(e.typ));
          check(e.tag, "msg line", int'(outLine), int'(e.line));
          check(e.tag, "msg token", int'(outToken), int'(e.tok));
        end
      end
      if (procDone) begin
        if (doneQ.size() == 0) check("R4", "unexpected completion token", int'(procToken), 999);
        else begin
          expDoneT d;
          d = doneQ.pop_front();
          check(d.tag, "done token", int'(procToken), int'(d.tok));
        end
      end
      if (misSpec) begin
        if (missQ.size() == 0) check("R9", "unexpected misSpec", 1, 0);
        else check(missQ.pop_front(), "misSpec pulse", 1, 1);
      end
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic expMsg(logic [1:0] v, logic [3:0] t, logic [LW-1:0] l, logic [TW-1:0] k, string tag);
    expMsgT e;
    e.vnet = v; e.typ = t; e.line = l; e.tok = k; e.tag = tag;
    msgQ.push_back(e);
  endtask

  task automatic expDone(logic [TW-1:0] k, string tag);
    expDoneT d;
    d.tok = k; d.tag = tag;
    doneQ.push_back(d);
  endtask

  task automatic msgIn(logic [1:0] v, logic [3:0] t, logic [LW-1:0] l, logic [TW-1:0] k);
    msgValid = 1'b1; msgVnet = v; msgType = t; msgLine = l; msgToken = k;
    step();
    msgValid = 1'b0; msgVnet = '0; msgType = '0; msgLine = '0; msgToken = '0;
  endtask

  task automatic procIn(logic [1:0] op, logic [LW-1:0] l, logic [TW-1:0] k);
    procValid = 1'b1; procOp = op; procLine = l; procWrToken = k;
    step();
    procValid = 1'b0; procOp = '0; procWrToken = '0;
  endtask

  task automatic chkState(logic [LW-1:0] l, int exp, string tag);
    procLine = l;
    #0.1;
    check(tag, $sformatf("state of line %0d", l), int'(procState), exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    for (int i = 0; i < NL; i++) chkState(LW'(i), 0, "R1");
    check("R1", "procReady", int'(procReady), 1);
    check("R1", "outValid", int'(outValid), 0);
    step();

    // R2 load miss then data fill
    expMsg(2'd0, 4'd0, 3'd1, 8'h00, "R2");
    procIn(2'd0, 3'd1, 8'h00);
    check("R2", "procReady while pending", int'(procReady), 0);
    expDone(8'h5A, "R2");
    msgIn(2'd2, 4'd8, 3'd1, 8'h5A);
    chkState(3'd1, 1, "R2");

    // R4 load hit
    expDone(8'h5A, "R4");
    procIn(2'd0, 3'd1, 8'h00);

    // R3 store miss, ack completes
    expMsg(2'd0, 4'd1, 3'd2, 8'h00, "R3");
    procIn(2'd1, 3'd2, 8'h33);
    expDone(8'h33, "R3");
    msgIn(2'd2, 4'd9, 3'd2, 8'h00);
    chkState(3'd2, 3, "R3");
    // R4 store hit
    expDone(8'h44, "R4");
    procIn(2'd1, 3'd2, 8'h44);

    // R7 read forwards to owner
    expMsg(2'd2, 4'd8, 3'd2, 8'h44, "R7");
    msgIn(2'd1, 4'd4, 3'd2, 8'h00);
    chkState(3'd2, 2, "R7");
    expMsg(2'd2, 4'd8, 3'd2, 8'h44, "R7");
    msgIn(2'd1, 4'd4, 3'd2, 8'h00);
    chkState(3'd2, 2, "R7");
    check("R7", "errSticky after repeated forwards", int'(errSticky), 0);

    // R5 evict owner, pending still serves reads
    expMsg(2'd0, 4'd2, 3'd2, 8'h44, "R5");
    procIn(2'd2, 3'd2, 8'h00);
    chkState(3'd2, 4, "R5");
    expMsg(2'd2, 4'd8, 3'd2, 8'h44, "R5");
    msgIn(2'd1, 4'd4, 3'd2, 8'h00);
    chkState(3'd2, 4, "R5");

    // R11 nack restores and reissues
    msgIn(2'd2, 4'd10, 3'd2, 8'h00);
    chkState(3'd2, 2, "R11");
    expMsg(2'd0, 4'd2, 3'd2, 8'h44, "R11");
    step();
    chkState(3'd2, 4, "R11");

    // R6 writeback ack
    expDone(8'h00, "R6");
    msgIn(2'd1, 4'd7, 3'd2, 8'h00);
    chkState(3'd2, 0, "R6");

    // R5 silent evict of a shared line
    expDone(8'h00, "R5");
    procIn(2'd2, 3'd1, 8'h00);
    chkState(3'd1, 0, "R5");

    // R12 invalidation of shared line
    expMsg(2'd0, 4'd0, 3'd3, 8'h00, "R2");
    procIn(2'd0, 3'd3, 8'h00);
    expDone(8'h11, "R2");
    msgIn(2'd2, 4'd8, 3'd3, 8'h11);
    expMsg(2'd2, 4'd9, 3'd3, 8'h00, "R12");
    msgIn(2'd1, 4'd6, 3'd3, 8'h00);
    chkState(3'd3, 0, "R12");

    // R3 store miss filled by data keeps store token; R8 exclusive forward
    expMsg(2'd0, 4'd1, 3'd4, 8'h00, "R3");
    procIn(2'd1, 3'd4, 8'h77);
    expDone(8'h77, "R3");
    msgIn(2'd2, 4'd8, 3'd4, 8'h99);
    chkState(3'd4, 3, "R3");
    expMsg(2'd2, 4'd8, 3'd4, 8'h77, "R8");
    msgIn(2'd1, 4'd5, 3'd4, 8'h00);
    chkState(3'd4, 0, "R8");

    // R8 exclusive forward to shared: invalidate, no reply
    expMsg(2'd0, 4'd0, 3'd5, 8'h00, "R2");
    procIn(2'd0, 3'd5, 8'h00);
    expDone(8'h22, "R2");
    msgIn(2'd2, 4'd8, 3'd5, 8'h22);
    msgIn(2'd1, 4'd5, 3'd5, 8'h00);
    chkState(3'd5, 0, "R8");

    // line 7 modified, to be wiped by recover
    expMsg(2'd0, 4'd1, 3'd7, 8'h00, "R3");
    procIn(2'd1, 3'd7, 8'hAB);
    expDone(8'hAB, "R3");
    msgIn(2'd2, 4'd9, 3'd7, 8'h00);
    chkState(3'd7, 3, "R10");

    // R9 exclusive forward to invalid line
    missQ.push_back("R9");
    msgIn(2'd1, 4'd5, 3'd6, 8'h00);
    chkState(3'd6, 0, "R9");
    chkState(3'd7, 3, "R9");
    check("R9", "errSticky", int'(errSticky), 1);
    check("R9", "procReady", int'(procReady), 0);
    step();
    check("R9", "misSpec after one cycle", int'(misSpec), 0);

    // R10 ignored while in error
    msgIn(2'd1, 4'd5, 3'd7, 8'h00);
    step();
    chkState(3'd7, 3, "R10");
    procIn(2'd0, 3'd0, 8'h00);
    step();
    check("R10", "errSticky held", int'(errSticky), 1);
    recover = 1'b1;
    step();
    recover = 1'b0;
    chkState(3'd7, 0, "R10");
    check("R10", "errSticky cleared", int'(errSticky), 0);
    check("R10", "procReady after recover", int'(procReady), 1);

    // R10 operation resumes
    expMsg(2'd0, 4'd0, 3'd7, 8'h00, "R10");
    procIn(2'd0, 3'd7, 8'h00);
    expDone(8'h3C, "R10");
    msgIn(2'd2, 4'd8, 3'd7, 8'h3C);
    chkState(3'd7, 1, "R10");

    repeat (3) step();
    check("R4", "leftover expected messages", msgQ.size(), 0);
    check("R4", "leftover expected completions", doneQ.size(), 0);
    check("R9", "leftover expected pulses", missQ.size(), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule